// File: doc/BRIEF.md
# 8-bit ALU with processor flags

This block is a purely combinational arithmetic and logic unit for an 8-bit processor datapath. The control logic presents an operation code, a register operand (accumulator or index), a memory operand and the current status flags. In the same cycle the block returns a result byte, the new negative, overflow, zero and carry flags, and one update-enable per flag. The register file and the status register stay outside. They write back only what the enables mark.

The operations are add and subtract with carry, bitwise AND, exclusive OR and inclusive OR, a bit test, compare, increment, decrement, left and right shifts, and rotates through the carry. Subtraction and compare use carry-as-not-borrow semantics. The carry input is taken from the carry bit of the flag input. When the decimal flag is set, arithmetic stays binary and an unsupported-mode output is raised instead.

Top module: `alu8_core`

## Requirements
- R1: Operation code 0 (add) returns the low 8 bits of A+B+C, where C is flags_in[0]. Carry out goes to C. Signed overflow goes to V. N is result bit 7 and Z is set when the result is zero. All four flags update.
- R2: Operation code 1 (subtract) returns A+~B+C, so C=1 means no borrow. C is the carry out of that sum, and V, N and Z follow the same rules as in R1. All four flags update.
- R3: Operation codes 2 (AND), 3 (exclusive OR) and 4 (inclusive OR) return the bitwise result and update only N and Z.
- R4: Operation code 5 (bit test) returns A unchanged. It sets N to B bit 7, V to B bit 6, and Z when A AND B is zero. It updates N, V and Z and leaves C alone.
- R5: Operation code 6 (compare) returns A unchanged. It sets C when A>=B unsigned, Z when A==B, and N to bit 7 of A-B. It updates N, Z and C.
- R6: Operation codes 7 (increment) and 8 (decrement) return A+1 or A-1 modulo 256. They update only N and Z, and the carry input has no effect.
- R7: Operation codes 9 (shift left) and 10 (logical shift right) move A by one bit and fill the vacated bit with 0. The bit shifted out goes to C. They update N, Z and C.
- R8: Operation codes 11 (rotate left) and 12 (rotate right) move A by one bit and fill the vacated bit with the old carry. The bit shifted out goes to C. They update N, Z and C.
- R9: flag_upd is ordered {N,V,Z,C}, the same order as flags_in and flags_out. Each flag whose enable is 0 is output equal to its flags_in bit.
- R10: With dec_mode high, add and subtract still give the binary result and bcd_unsupported is 1. For every other operation, and whenever dec_mode is low, bcd_unsupported is 0.
- R11: Operation codes 13 to 15 return A, clear all enables and pass all flags through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code |
| opa | input | 8 | Register operand A |
| opb | input | 8 | Memory operand B |
| flags_in | input | 4 | Current flags {N,V,Z,C}; bit 0 is the carry input |
| dec_mode | input | 1 | Current decimal flag |
| result | output | 8 | Result byte |
| flags_out | output | 4 | New flags {N,V,Z,C} |
| flag_upd | output | 4 | Per-flag update enable {N,V,Z,C} |
| bcd_unsupported | output | 1 | Decimal arithmetic requested but not performed |

## Verification
The assertions are immediate checks that run whenever the inputs settle. They assume op_sel, the operands and the flags are all known (non-X) values. The 4-bit op_sel field covers every code, so they assume no protocol on the sequence of operations. The bench meets these assumptions by driving every input from fully specified constants and loops, with no undriven bits. It changes inputs only between clock edges, and it samples a fixed delay after each change.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_XOR  = 4'd3,
    OP_OR   = 4'd4,
    OP_BITT = 4'd5,
    OP_CMP  = 4'd6,
    OP_INC  = 4'd7,
    OP_DEC  = 4'd8,
    OP_SHL  = 4'd9,
    OP_SHR  = 4'd10,
    OP_ROL  = 4'd11,
    OP_ROR  = 4'd12,
    OP_PASS = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } alu_op_e;

  // flag positions inside the {N,V,Z,C} vectors
  localparam int FL_N = 3;
  localparam int FL_V = 2;
  localparam int FL_Z = 1;
  localparam int FL_C = 0;
  localparam int FL_W = 4;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] res,
  output logic             n,
  output logic             v,
  output logic             z,
  output logic             c
);

  localparam int MSB = WIDTH - 1;

  function automatic logic [WIDTH:0] add_wide(input logic [WIDTH-1:0] x,
                                              input logic [WIDTH-1:0] y,
                                              input logic             ci);
    return {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, ci};
  endfunction

  function automatic logic sign_ovf(input logic xs, input logic ys, input logic rs);
    return (xs == ys) && (rs != xs);
  endfunction

  logic [WIDTH:0]   sum_w;
  logic [WIDTH-1:0] b_eff;
  logic             ci_eff;

  always_comb begin
    b_eff  = b;
    ci_eff = cin;
    unique case (op)
      OP_SUB:  b_eff = ~b;
      OP_CMP:  begin b_eff = ~b; ci_eff = 1'b1; end
      OP_INC:  begin b_eff = '0; ci_eff = 1'b1; end
      OP_DEC:  begin b_eff = '1; ci_eff = 1'b0; end
      default: ;
    endcase
    sum_w = add_wide(a, b_eff, ci_eff);
    res   = sum_w[MSB:0];
    c     = sum_w[WIDTH];
    v     = sign_ovf(a[MSB], b_eff[MSB], sum_w[MSB]);
    n     = sum_w[MSB];
    z     = (sum_w[MSB:0] == '0);
  end

  always_comb begin
    if (op == OP_CMP && z) AST_CMP_EQ_SETS_C: assert (c);                   // R5
    if (op == OP_CMP && a < b) AST_CMP_LT_CLEARS_C: assert (!c);            // R5
    if (op == OP_SUB && cin && !c) AST_SUB_BORROW_LT: assert (a < b);       // R2
    if (op == OP_ADD && a[MSB] != b[MSB]) AST_ADD_MIXED_NO_OVF: assert (!v); // R1
  end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] res,
  output logic             n,
  output logic             v,
  output logic             z
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] masked;

  always_comb begin
    masked = a & b;
    v      = 1'b0;
    unique case (op)
      OP_XOR:  res = a ^ b;
      OP_OR:   res = a | b;
      OP_BITT: res = a;
      default: res = masked;
    endcase
    if (op == OP_BITT) begin
      n = b[MSB];
      v = b[MSB-1];
      z = (masked == '0);
    end else begin
      n = res[MSB];
      z = (res == '0);
    end
  end

  always_comb begin
    if (op == OP_BITT) AST_BIT_KEEPS_A: assert (res == a);                  // R4
    if (op == OP_AND) AST_AND_WITHIN_A: assert ((res & ~a) == '0);           // R3
    if (op == OP_OR) AST_OR_COVERS_B: assert ((res & b) == b);               // R3
  end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic             cin,
  output logic [WIDTH-1:0] res,
  output logic             n,
  output logic             z,
  output logic             c
);

  localparam int MSB = WIDTH - 1;

  logic left;
  logic fill;

  always_comb begin
    left = (op == OP_SHL) || (op == OP_ROL);
    fill = ((op == OP_ROL) || (op == OP_ROR)) ? cin : 1'b0;
    if (left) begin
      res = {a[MSB-1:0], fill};
      c   = a[MSB];
    end else begin
      res = {fill, a[MSB:1]};
      c   = a[0];
    end
    n = res[MSB];
    z = (res == '0);
  end

  always_comb begin
    if (op == OP_ROL || op == OP_ROR)
      AST_ROT_KEEPS_ONES: assert ($countones({c, res}) == $countones({cin, a})); // R8
    if (op == OP_SHL) AST_SHL_FILL_ZERO: assert (res[0] == 1'b0);                 // R7
    if (op == OP_SHR) AST_SHR_FILL_ZERO: assert (res[MSB] == 1'b0);               // R7
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [3:0]       op_sel,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [3:0]       flags_in,
  input  logic             dec_mode,
  output logic [WIDTH-1:0] result,
  output logic [3:0]       flags_out,
  output logic [3:0]       flag_upd,
  output logic             bcd_unsupported
);

  alu_op_e op;
  assign op = alu_op_e'(op_sel);

  // named internal results, one set per unit
  logic [WIDTH-1:0] ar_res, lg_res, sh_res;
  logic ar_n, ar_v, ar_z, ar_c;
  logic lg_n, lg_v, lg_z;
  logic sh_n, sh_z, sh_c;
  logic [FL_W-1:0] new_fl;
  logic is_arith;

  alu8_arith #(.WIDTH(WIDTH)) u_arith (
    .op(op), .a(opa), .b(opb), .cin(flags_in[FL_C]),
    .res(ar_res), .n(ar_n), .v(ar_v), .z(ar_z), .c(ar_c)
  );

  alu8_logic #(.WIDTH(WIDTH)) u_logic (
    .op(op), .a(opa), .b(opb),
    .res(lg_res), .n(lg_n), .v(lg_v), .z(lg_z)
  );

  alu8_shift #(.WIDTH(WIDTH)) u_shift (
    .op(op), .a(opa), .cin(flags_in[FL_C]),
    .res(sh_res), .n(sh_n), .z(sh_z), .c(sh_c)
  );

  always_comb begin
    result   = opa;
    new_fl   = flags_in;
    flag_upd = 4'b0000;
    unique case (op)
      OP_ADD, OP_SUB: begin
        result = ar_res; new_fl = {ar_n, ar_v, ar_z, ar_c}; flag_upd = 4'b1111;
      end
      OP_CMP: begin
        new_fl = {ar_n, 1'b0, ar_z, ar_c}; flag_upd = 4'b1011;
      end
      OP_INC, OP_DEC: begin
        result = ar_res; new_fl = {ar_n, 1'b0, ar_z, 1'b0}; flag_upd = 4'b1010;
      end
      OP_AND, OP_XOR, OP_OR: begin
        result = lg_res; new_fl = {lg_n, 1'b0, lg_z, 1'b0}; flag_upd = 4'b1010;
      end
      OP_BITT: begin
        result = lg_res; new_fl = {lg_n, lg_v, lg_z, 1'b0}; flag_upd = 4'b1110;
      end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        result = sh_res; new_fl = {sh_n, 1'b0, sh_z, sh_c}; flag_upd = 4'b1011;
      end
      default: ;
    endcase
  end

  // keep every flag whose enable is low
  for (genvar k = 0; k < FL_W; k++) begin : g_merge
    assign flags_out[k] = flag_upd[k] ? new_fl[k] : flags_in[k];
  end

  assign is_arith        = (op == OP_ADD) || (op == OP_SUB);
  assign bcd_unsupported = dec_mode && is_arith;

  always_comb begin
    for (int k = 0; k < FL_W; k++)
      if (!flag_upd[k]) AST_HOLD_UNUPDATED: assert (flags_out[k] == flags_in[k]); // R9
    if (bcd_unsupported) AST_BCD_ONLY_ARITH: assert (op_sel <= 4'd1 && dec_mode);  // R10
    if (op_sel >= 4'd13) AST_PASS_IDLE: assert (flag_upd == 4'b0000 && result == opa); // R11
    if (op_sel == 4'd6) AST_CMP_KEEPS_A: assert (result == opa);                   // R5
  end

endmodule

// File: tb/test_alu8_core.sv
module test_alu8_core;

  logic       clk = 1'b0;
  logic [3:0] op_sel;
  logic [7:0] opa, opb;
  logic [3:0] flags_in;
  logic       dec_mode;
  logic [7:0] result;
  logic [3:0] flags_out, flag_upd;
  logic       bcd_unsupported;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  alu8_core i_alu8_core (
    .op_sel(op_sel), .opa(opa), .opb(opb), .flags_in(flags_in), .dec_mode(dec_mode),
    .result(result), .flags_out(flags_out), .flag_upd(flag_upd),
    .bcd_unsupported(bcd_unsupported)
  );

  // {req, op, a, b, flags_in, dec, exp_result, exp_flags, exp_upd, exp_bcd}
  localparam int NV = 23;
  localparam logic [45:0] VECS [NV] = '{
    {4'd1, 4'd0, 8'h50, 8'h50, 4'b0000, 1'b0, 8'hA0, 4'b1100, 4'b1111, 1'b0}, // R1 pos overflow
    {4'd1, 4'd0, 8'hFF, 8'h01, 4'b0001, 1'b0, 8'h01, 4'b0001, 4'b1111, 1'b0}, // R1 carry in/out
    {4'd1, 4'd0, 8'h80, 8'h80, 4'b0000, 1'b0, 8'h00, 4'b0111, 4'b1111, 1'b0}, // R1 neg overflow
    {4'd2, 4'd1, 8'h50, 8'hF0, 4'b0001, 1'b0, 8'h60, 4'b0000, 4'b1111, 1'b0}, // R2 borrow
    {4'd2, 4'd1, 8'h50, 8'hB0, 4'b0001, 1'b0, 8'hA0, 4'b1100, 4'b1111, 1'b0}, // R2 overflow
    {4'd2, 4'd1, 8'h05, 8'h03, 4'b0000, 1'b0, 8'h01, 4'b0001, 4'b1111, 1'b0}, // R2 borrow in
    {4'd3, 4'd2, 8'hF0, 8'h3C, 4'b0101, 1'b0, 8'h30, 4'b0101, 4'b1010, 1'b0}, // R3 and
    {4'd3, 4'd3, 8'hAA, 8'hAA, 4'b1000, 1'b0, 8'h00, 4'b0010, 4'b1010, 1'b0}, // R3 xor
    {4'd3, 4'd4, 8'h01, 8'h80, 4'b0100, 1'b0, 8'h81, 4'b1100, 4'b1010, 1'b0}, // R3 or
    {4'd4, 4'd5, 8'h0F, 8'hC0, 4'b0001, 1'b0, 8'h0F, 4'b1111, 4'b1110, 1'b0}, // R4 bit set
    {4'd4, 4'd5, 8'hFF, 8'h01, 4'b1110, 1'b0, 8'hFF, 4'b0000, 4'b1110, 1'b0}, // R4 bit clear
    {4'd5, 4'd6, 8'h40, 8'h40, 4'b0100, 1'b0, 8'h40, 4'b0111, 4'b1011, 1'b0}, // R5 equal
    {4'd5, 4'd6, 8'h10, 8'h20, 4'b0000, 1'b0, 8'h10, 4'b1000, 4'b1011, 1'b0}, // R5 less
    {4'd6, 4'd7, 8'hFF, 8'h00, 4'b0001, 1'b0, 8'h00, 4'b0011, 4'b1010, 1'b0}, // R6 inc wrap
    {4'd6, 4'd8, 8'h00, 8'h00, 4'b0000, 1'b0, 8'hFF, 4'b1000, 4'b1010, 1'b0}, // R6 dec wrap
    {4'd7, 4'd9, 8'h81, 8'h00, 4'b0001, 1'b0, 8'h02, 4'b0001, 4'b1011, 1'b0}, // R7 shl
    {4'd7, 4'd10, 8'h01, 8'h00, 4'b1000, 1'b0, 8'h00, 4'b0011, 4'b1011, 1'b0}, // R7 shr
    {4'd8, 4'd11, 8'h80, 8'h00, 4'b0001, 1'b0, 8'h01, 4'b0001, 4'b1011, 1'b0}, // R8 rol
    {4'd8, 4'd12, 8'h01, 8'h00, 4'b0001, 1'b0, 8'h80, 4'b1001, 4'b1011, 1'b0}, // R8 ror
    {4'd8, 4'd12, 8'h02, 8'h00, 4'b0000, 1'b0, 8'h01, 4'b0000, 4'b1011, 1'b0}, // R8 ror c=0
    {4'd10, 4'd0, 8'h09, 8'h01, 4'b0000, 1'b1, 8'h0A, 4'b0000, 4'b1111, 1'b1}, // R10 add dec
    {4'd10, 4'd2, 8'hFF, 8'hFF, 4'b0000, 1'b1, 8'hFF, 4'b1000, 4'b1010, 1'b0}, // R10 and dec
    {4'd11, 4'd13, 8'h5A, 8'h33, 4'b1011, 1'b0, 8'h5A, 4'b1011, 4'b0000, 1'b0}  // R11 pass
  };

  task automatic apply(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic [3:0] fl, input logic dm);
    @(negedge clk);
    op_sel = op; opa = a; opb = b; flags_in = fl; dec_mode = dm;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // independent arithmetic model for sweeps
  function automatic logic [11:0] model_addsub(input bit sub, input int a, input int b, input int c);
    int bb, s, sa, sb, ss;
    logic [7:0] r;
    bb = sub ? (255 - b) : b;
    s  = a + bb + c;
    r  = s[7:0];
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    ss = sub ? (sa - sb - (1 - c)) : (sa + sb + c);
    return {r, r[7], (ss > 127 || ss < -128), (r == 8'h00), (s > 255)};
  endfunction

  initial begin
    op_sel = 4'd13; opa = '0; opb = '0; flags_in = '0; dec_mode = 1'b0;
    fork
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          n_chk++; n_bad++;
          $display("FAIL watchdog: actual timeout expected completion");
          $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
          $finish;
        end
      end
    join_none

    // idle state: pass code with all-zero inputs
    apply(4'd13, 8'h00, 8'h00, 4'b0000, 1'b0);
    check("R11 idle result", 32'(result), 32'h0);
    check("R11 idle upd", 32'(flag_upd), 32'h0);
    check("R10 idle bcd", 32'(bcd_unsupported), 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [45:0] vv;
      string tag;
      vv = VECS[i];
      apply(vv[41:38], vv[37:30], vv[29:22], vv[21:18], vv[17]);
      tag = $sformatf("R%0d vec%0d", vv[45:42], i);
      check({tag, " result"}, 32'(result), 32'(vv[16:9]));
      check({tag, " flags"}, 32'(flags_out), 32'(vv[8:5]));
      check({tag, " R9 upd"}, 32'(flag_upd), 32'(vv[4:1]));
      check({tag, " bcd"}, 32'(bcd_unsupported), 32'(vv[0]));
    end

    // R1 / R2 sweep against the bench model
    for (int a = 0; a < 256; a += 17) begin
      for (int b = 0; b < 256; b += 23) begin
        for (int c = 0; c < 2; c++) begin
          for (int s = 0; s < 2; s++) begin
            logic [11:0] e;
            e = model_addsub(s[0], a, b, c);
            apply(s[0] ? 4'd1 : 4'd0, 8'(a), 8'(b), {3'b000, c[0]}, 1'b0);
            check(s[0] ? "R2 sweep" : "R1 sweep", {result, flags_out}, 32'(e));
          end
        end
      end
    end

    // R5 compare sweep
    for (int a = 0; a < 256; a += 37) begin
      for (int b = 0; b < 256; b += 41) begin
        logic [7:0] d;
        d = 8'(a - b);
        apply(4'd6, 8'(a), 8'(b), 4'b0100, 1'b0);
        check("R5 cmp sweep", 32'(flags_out), {28'h0, d[7], 1'b1, a == b, a >= b});
      end
    end

    // R6 carry input has no effect on increment
    apply(4'd7, 8'h7F, 8'h00, 4'b0001, 1'b0);
    check("R6 inc ignores carry", {result, flags_out}, {20'h0, 8'h80, 4'b1001});
    // R3 V and C pass through exclusive OR with both set
    apply(4'd3, 8'h0F, 8'hF0, 4'b0101, 1'b0);
    check("R3 xor keeps V C", {result, flags_out}, {20'h0, 8'hFF, 4'b1101});
    // R10 subtract in decimal mode stays binary
    apply(4'd1, 8'h10, 8'h01, 4'b0001, 1'b1);
    check("R10 sub dec", {result, 3'b000, bcd_unsupported}, {20'h0, 8'h0F, 4'b0001});
    // R11 reserved codes 14 and 15
    apply(4'd14, 8'hC3, 8'hFF, 4'b0110, 1'b1);
    check("R11 code14", {result, flags_out, flag_upd}, {16'h0, 8'hC3, 4'b0110, 4'b0000});
    apply(4'd15, 8'h3C, 8'h00, 4'b1001, 1'b0);
    check("R11 code15", {result, flags_out, flag_upd}, {16'h0, 8'h3C, 4'b1001, 4'b0000});
    // R7 shift right ignores carry in
    apply(4'd10, 8'h80, 8'h00, 4'b0001, 1'b0);
    check("R7 shr fill zero", {result, flags_out}, {20'h0, 8'h40, 4'b0000});
    // R8 rotate left with carry fills bit 0
    apply(4'd11, 8'h00, 8'h00, 4'b0001, 1'b0);
    check("R8 rol fill", {result, flags_out}, {20'h0, 8'h01, 4'b0000});
    // R4 bit test leaves C set
    apply(4'd5, 8'h01, 8'h41, 4'b0001, 1'b0);
    check("R4 bit keeps C", {result, flags_out}, {20'h0, 8'h01, 4'b0101});

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule